// File: doc/BRIEF.md
# SMI Source Enable and Aggregation

This block is the enable-and-collect stage of a power-management interrupt controller. Two byte-wide enable registers sit on a simple register bus. One register holds the per-source enables for the suspend/resume button and the battery-low input, plus the power-management callback enable. The other holds master enables for each class of event: system events, software and external SMI, local traps, local standby timers, the global standby timer and the two suspend inputs. A write to this second register can also raise a software SMI.

Event sources arrive as strobes or as active-low inputs. Each source that passes its enables sets a sticky status flag. The active-low SMI output stays asserted while any flag is set. Software clears a flag by writing a one to its bit on the clear port. A 16-bit global standby down-counter is loaded when its enable is first set and counts down on a prescaled tick. Any activity strobe reloads it. When it expires it raises its own flag. A separate callback path turns a write to the power-management control register into a one-cycle interrupt request.

Top module: `pm_smi_gate`

## Requirements
- R1: While reset is held and right after it, both enable registers read 00h, all status flags are 0, `smi_n_o` is 1 and `pirq_o` is 0.
- R2: The miscellaneous register is at address C2h, and only its bits 3:1 are stored. The global register is at C3h, and only its bits 7, 6 and 4:1 are stored. All other bits read 0, and any other address reads 00h.
- R3: A write to C3h whose data has bit 0 and bit 6 both set raises status bit 1 (software SMI). Bit 0 reads back 0, and a write with bit 0 set but bit 6 clear raises nothing.
- R4: A `sys_evt_i` strobe sets status bit 0 only while C3h bit 7 is set.
- R5: A falling edge on `ext_smi_n_i` sets status bit 2 only when `ext_en_i` and C3h bit 6 are both set. A level held low raises one event only.
- R6: A `trap_i` strobe sets status bit 3 only while C3h bit 4 is set. A `lstby_i` strobe sets status bit 4 only while C3h bit 3 is set.
- R7: A falling edge on `button_n_i` sets status bit 6 only when C2h bit 2 and C3h bit 1 are set. A falling edge on `batlow_n_i` sets status bit 7 only when C2h bit 1 and C3h bit 1 are set.
- R8: A write that sets C3h bit 2 while it is clear loads `gstby_init_i` into the counter. Each cycle with `tick_i` high decrements it. The tick that takes it from 1 to 0 sets status bit 5. An initial value of 0 never expires.
- R9: While C3h bit 2 is set, `activity_i` reloads the counter from `gstby_init_i`. Clearing C3h bit 2 empties the counter so that it cannot expire.
- R10: `smi_n_o` is 0 exactly while some status bit is set. A status bit stays set until a 1 is written to its bit of `stat_clr_i`. If a new event and a clear hit the same bit in the same cycle, the bit stays set.
- R11: `pirq_o` is high for one cycle, the cycle after `apmc_wr_i`, when C2h bit 3 and `apmc_smi_en_i` are both set. Otherwise it stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr_i | input | 8 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_we_i | input | 1 | Write strobe |
| bus_rdata_o | output | 8 | Read data for the addressed register |
| sys_evt_i | input | 1 | System event strobe |
| ext_smi_n_i | input | 1 | External SMI request, active low |
| ext_en_i | input | 1 | Per-source enable for the external SMI |
| trap_i | input | 1 | Local trap strobe |
| lstby_i | input | 1 | Local standby timer strobe |
| button_n_i | input | 1 | Suspend/resume button, active low |
| batlow_n_i | input | 1 | Battery-low, active low |
| activity_i | input | 1 | Activity strobe that reloads the global standby counter |
| tick_i | input | 1 | Prescaled count enable |
| gstby_init_i | input | 16 | Initial value of the global standby counter |
| apmc_wr_i | input | 1 | Write to the power-management control register |
| apmc_smi_en_i | input | 1 | Enable of the control-register SMI |
| stat_clr_i | input | 8 | Write-one-to-clear for the status flags |
| stat_o | output | 8 | Sticky status flags |
| smi_n_o | output | 1 | SMI request, active low |
| pirq_o | output | 1 | Callback interrupt request pulse |

## Verification
Two functions can meet on the same status bit in the same clock: software clearing a flag, and a fresh enabled event setting it again. The bench first latches the trap flag. It then pulses the trap strobe and that flag's clear bit together in one cycle, and expects the flag and the SMI output to stay asserted. A clear alone in the next cycle must then drop them. In the same way, a timer write is issued in a cycle with no tick, and the reload by activity is placed between tick bursts. This keeps each counter value traceable to a single cause.

// File: rtl/pm_smi_pkg.sv
package pm_smi_pkg;

  parameter int unsigned REG_W   = 8;
  parameter int unsigned ADDR_W  = 8;
  parameter int unsigned STAT_W  = 8;
  parameter int unsigned GSTBY_W = 16;

  localparam logic [ADDR_W-1:0] MISC_ADDR = 8'hC2;
  localparam logic [ADDR_W-1:0] GLOB_ADDR = 8'hC3;

  // Writable bit masks of the two enable registers
  localparam logic [REG_W-1:0] MISC_MASK = 8'h0E;
  localparam logic [REG_W-1:0] GLOB_MASK = 8'hDE;

  // Enable bit positions
  localparam int unsigned M_CB    = 3;
  localparam int unsigned M_BTN   = 2;
  localparam int unsigned M_BAT   = 1;
  localparam int unsigned G_SYS   = 7;
  localparam int unsigned G_SWEXT = 6;
  localparam int unsigned G_TRAP  = 4;
  localparam int unsigned G_LSTBY = 3;
  localparam int unsigned G_GSTBY = 2;
  localparam int unsigned G_SUSP  = 1;
  localparam int unsigned G_SWTRG = 0;

  // Status flag positions
  localparam int unsigned S_SYS   = 0;
  localparam int unsigned S_SW    = 1;
  localparam int unsigned S_EXT   = 2;
  localparam int unsigned S_TRAP  = 3;
  localparam int unsigned S_LSTBY = 4;
  localparam int unsigned S_GSTBY = 5;
  localparam int unsigned S_BTN   = 6;
  localparam int unsigned S_BAT   = 7;

  // Index of each active-low input in the edge detector
  localparam int unsigned E_EXT = 0;
  localparam int unsigned E_BTN = 1;
  localparam int unsigned E_BAT = 2;
  localparam int unsigned N_EDGE = 3;

  // Sticky flag update: a new event wins over a clear
  function automatic logic [STAT_W-1:0] stat_next(
      input logic [STAT_W-1:0] cur,
      input logic [STAT_W-1:0] set,
      input logic [STAT_W-1:0] clr);
    return (cur & ~clr) | set;
  endfunction

  // Next counter value of the global standby timer
  function automatic logic [GSTBY_W-1:0] gstby_next(
      input logic               en,
      input logic               load,
      input logic               act,
      input logic               tick,
      input logic [GSTBY_W-1:0] cnt,
      input logic [GSTBY_W-1:0] init);
    logic [GSTBY_W-1:0] r;
    if (load)                       r = init;
    else if (!en)                   r = '0;
    else if (act)                   r = init;
    else if (tick && (cnt != '0))   r = cnt - 1'b1;
    else                            r = cnt;
    return r;
  endfunction

  // Expiry: the tick that takes the counter from one to zero
  function automatic logic gstby_fire(
      input logic               en,
      input logic               load,
      input logic               act,
      input logic               tick,
      input logic [GSTBY_W-1:0] cnt);
    return en && !load && !act && tick && (cnt == GSTBY_W'(1));
  endfunction

endpackage

// File: rtl/pm_smi_regs.sv
module pm_smi_regs
  import pm_smi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic              we_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic [REG_W-1:0]  misc_o,
  output logic [REG_W-1:0]  glob_o,
  output logic              sw_trig_o,
  output logic              gstby_load_o
);

  logic [REG_W-1:0] misc_q, glob_q;
  logic             wr_misc, wr_glob;

  assign wr_misc = we_i && (addr_i == MISC_ADDR);
  assign wr_glob = we_i && (addr_i == GLOB_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      misc_q <= '0;
      glob_q <= '0;
    end else begin
      if (wr_misc) misc_q <= wdata_i & MISC_MASK;
      if (wr_glob) glob_q <= wdata_i & GLOB_MASK;
    end
  end

  always_comb begin
    if (addr_i == MISC_ADDR)      rdata_o = misc_q;
    else if (addr_i == GLOB_ADDR) rdata_o = glob_q;
    else                          rdata_o = '0;
  end

  assign sw_trig_o    = wr_glob && wdata_i[G_SWTRG] && wdata_i[G_SWEXT];
  assign gstby_load_o = wr_glob && wdata_i[G_GSTBY] && !glob_q[G_GSTBY];
  assign misc_o       = misc_q;
  assign glob_o       = glob_q;

endmodule

// File: rtl/pm_smi_edge.sv
module pm_smi_edge
  import pm_smi_pkg::*;
#(
  parameter int unsigned N = N_EDGE
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] in_n_i,
  output logic [N-1:0] fall_o
);

  for (genvar i = 0; i < N; i++) begin : g_edge
    logic prev_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b1;
      else        prev_q <= in_n_i[i];
    end
    assign fall_o[i] = prev_q && !in_n_i[i];
  end

endmodule

// File: rtl/pm_gstby_timer.sv
module pm_gstby_timer
  import pm_smi_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en_i,
  input  logic               load_i,
  input  logic               act_i,
  input  logic               tick_i,
  input  logic [GSTBY_W-1:0] init_i,
  output logic [GSTBY_W-1:0] cnt_o,
  output logic               expire_o
);

  logic [GSTBY_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= gstby_next(en_i, load_i, act_i, tick_i, cnt_q, init_i);
  end

  assign expire_o = gstby_fire(en_i, load_i, act_i, tick_i, cnt_q);
  assign cnt_o    = cnt_q;

endmodule

// File: rtl/pm_smi_gate.sv
module pm_smi_gate
  import pm_smi_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic [REG_W-1:0]   bus_wdata_i,
  input  logic               bus_we_i,
  output logic [REG_W-1:0]   bus_rdata_o,
  input  logic               sys_evt_i,
  input  logic               ext_smi_n_i,
  input  logic               ext_en_i,
  input  logic               trap_i,
  input  logic               lstby_i,
  input  logic               button_n_i,
  input  logic               batlow_n_i,
  input  logic               activity_i,
  input  logic               tick_i,
  input  logic [GSTBY_W-1:0] gstby_init_i,
  input  logic               apmc_wr_i,
  input  logic               apmc_smi_en_i,
  input  logic [STAT_W-1:0]  stat_clr_i,
  output logic [STAT_W-1:0]  stat_o,
  output logic               smi_n_o,
  output logic               pirq_o
);

  logic [REG_W-1:0]   misc_q, glob_q;
  logic               sw_trig, gstby_load, gstby_expire;
  logic [GSTBY_W-1:0] gstby_cnt;
  logic [N_EDGE-1:0]  fall;
  logic [STAT_W-1:0]  hit;
  logic [STAT_W-1:0]  stat_q;
  logic               cb_hit, pirq_q;

  pm_smi_regs u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .addr_i       (bus_addr_i),
    .wdata_i      (bus_wdata_i),
    .we_i         (bus_we_i),
    .rdata_o      (bus_rdata_o),
    .misc_o       (misc_q),
    .glob_o       (glob_q),
    .sw_trig_o    (sw_trig),
    .gstby_load_o (gstby_load)
  );

  pm_smi_edge #(.N(N_EDGE)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .in_n_i ({batlow_n_i, button_n_i, ext_smi_n_i}),
    .fall_o (fall)
  );

  pm_gstby_timer u_gstby (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_i     (glob_q[G_GSTBY]),
    .load_i   (gstby_load),
    .act_i    (activity_i),
    .tick_i   (tick_i),
    .init_i   (gstby_init_i),
    .cnt_o    (gstby_cnt),
    .expire_o (gstby_expire)
  );

  // Gated event per status position
  always_comb begin
    hit          = '0;
    hit[S_SYS]   = sys_evt_i && glob_q[G_SYS];
    hit[S_SW]    = sw_trig;
    hit[S_EXT]   = fall[E_EXT] && ext_en_i && glob_q[G_SWEXT];
    hit[S_TRAP]  = trap_i && glob_q[G_TRAP];
    hit[S_LSTBY] = lstby_i && glob_q[G_LSTBY];
    hit[S_GSTBY] = gstby_expire;
    hit[S_BTN]   = fall[E_BTN] && misc_q[M_BTN] && glob_q[G_SUSP];
    hit[S_BAT]   = fall[E_BAT] && misc_q[M_BAT] && glob_q[G_SUSP];
  end

  assign cb_hit = apmc_wr_i && apmc_smi_en_i && misc_q[M_CB];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      pirq_q <= 1'b0;
    end else begin
      stat_q <= stat_next(stat_q, hit, stat_clr_i);
      pirq_q <= cb_hit;
    end
  end

  assign stat_o  = stat_q;
  assign smi_n_o = ~|stat_q;
  assign pirq_o  = pirq_q;

endmodule

// File: rtl/pm_smi_gate_chk.sv
module pm_smi_gate_chk
  import pm_smi_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic [ADDR_W-1:0]  addr,
  input logic [REG_W-1:0]   rdata,
  input logic [REG_W-1:0]   misc_q,
  input logic [REG_W-1:0]   glob_q,
  input logic [STAT_W-1:0]  hit,
  input logic [STAT_W-1:0]  stat,
  input logic [STAT_W-1:0]  clr,
  input logic               smi_n,
  input logic               pirq,
  input logic               apmc_wr,
  input logic               apmc_en,
  input logic               expire,
  input logic [GSTBY_W-1:0] cnt
);

  AST_MISC_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == MISC_ADDR) |-> ((rdata & ~MISC_MASK) == '0)); // R2

  AST_GLOB_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == GLOB_ADDR) |-> ((rdata & ~GLOB_MASK) == '0)); // R2

  AST_SYS_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    !glob_q[G_SYS] |-> !hit[S_SYS]); // R4

  AST_SUSP_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
    !glob_q[G_SUSP] |-> (!hit[S_BTN] && !hit[S_BAT])); // R7

  AST_EXPIRE_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (cnt == '0)); // R8

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(stat) & ~$past(clr)) & ~stat) == '0)); // R10

  AST_HIT_LOWERS_SMI: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit) |=> !smi_n); // R10

  AST_PIRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    pirq |-> $past(apmc_wr && apmc_en && misc_q[M_CB])); // R11

endmodule

bind pm_smi_gate pm_smi_gate_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .addr    (bus_addr_i),
  .rdata   (bus_rdata_o),
  .misc_q  (misc_q),
  .glob_q  (glob_q),
  .hit     (hit),
  .stat    (stat_o),
  .clr     (stat_clr_i),
  .smi_n   (smi_n_o),
  .pirq    (pirq_o),
  .apmc_wr (apmc_wr_i),
  .apmc_en (apmc_smi_en_i),
  .expire  (gstby_expire),
  .cnt     (gstby_cnt)
);

// File: tb/pm_smi_gate_bench.sv
`timescale 1ns/1ps
module pm_smi_gate_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr_i = '0, bus_wdata_i = '0, bus_rdata_o;
  logic        bus_we_i = 0;
  logic        sys_evt_i = 0, ext_smi_n_i = 1, ext_en_i = 0, trap_i = 0, lstby_i = 0;
  logic        button_n_i = 1, batlow_n_i = 1, activity_i = 0, tick_i = 0;
  logic [15:0] gstby_init_i = '0;
  logic        apmc_wr_i = 0, apmc_smi_en_i = 0;
  logic [7:0]  stat_clr_i = '0, stat_o;
  logic        smi_n_o, pirq_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pm_smi_gate u_pm_smi_gate (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr_i = a; bus_wdata_i = d; bus_we_i = 1;
    @(negedge clk);
    bus_we_i = 0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [7:0] exp);
    bus_addr_i = a;
    #1;
    chk(req, bus_rdata_o, exp);
  endtask

  task automatic clr_all();
    @(negedge clk); stat_clr_i = 8'hFF;
    @(negedge clk); stat_clr_i = 8'h00;
  endtask

  task automatic t_reset();
    rd_chk("R1 misc reset", 8'hC2, 8'h00);
    rd_chk("R1 glob reset", 8'hC3, 8'h00);
    chk("R1 status reset", stat_o, 8'h00);
    chk("R1 smi reset", smi_n_o, 1'b1);
    chk("R1 pirq reset", pirq_o, 1'b0);
  endtask

  task automatic t_regs();
    wr(8'hC2, 8'hFF);
    rd_chk("R2 misc mask", 8'hC2, 8'h0E);
    wr(8'hC3, 8'hFF);
    rd_chk("R2 glob mask", 8'hC3, 8'hDE);
    rd_chk("R2 other addr", 8'h10, 8'h00);
    wr(8'hC3, 8'h00);
    wr(8'hC2, 8'h00);
    rd_chk("R2 glob cleared", 8'hC3, 8'h00);
    clr_all();
  endtask

  task automatic t_sw();
    wr(8'hC3, 8'h01);
    chk("R3 trigger without master", stat_o[1], 1'b0);
    wr(8'hC3, 8'h41);
    chk("R3 software smi", stat_o, 8'h02);
    chk("R10 smi low", smi_n_o, 1'b0);
    rd_chk("R3 trigger bit reads 0", 8'hC3, 8'h40);
    clr_all();
    chk("R10 cleared", smi_n_o, 1'b1);
    wr(8'hC3, 8'h00);
  endtask

  task automatic t_sys();
    @(negedge clk); sys_evt_i = 1;
    @(negedge clk); sys_evt_i = 0;
    chk("R4 masked", stat_o, 8'h00);
    wr(8'hC3, 8'h80);
    @(negedge clk); sys_evt_i = 1;
    @(negedge clk); sys_evt_i = 0;
    chk("R4 enabled", stat_o, 8'h01);
    clr_all();
    wr(8'hC3, 8'h00);
  endtask

  task automatic t_ext();
    wr(8'hC3, 8'h40);
    @(negedge clk); ext_smi_n_i = 0;
    @(negedge clk);
    chk("R5 per-source enable off", stat_o, 8'h00);
    ext_smi_n_i = 1; ext_en_i = 1;
    @(negedge clk); ext_smi_n_i = 0;
    @(negedge clk);
    chk("R5 edge sets", stat_o, 8'h04);
    stat_clr_i = 8'h04;
    @(negedge clk); stat_clr_i = 8'h00;
    repeat (3) @(negedge clk);
    chk("R5 held low one event", stat_o, 8'h00);
    ext_smi_n_i = 1;
    wr(8'hC3, 8'h00);
    @(negedge clk); ext_smi_n_i = 0;
    @(negedge clk);
    chk("R5 master off", stat_o, 8'h00);
    ext_smi_n_i = 1; ext_en_i = 0;
    @(negedge clk);
  endtask

  task automatic t_trap_lstby();
    @(negedge clk); trap_i = 1; lstby_i = 1;
    @(negedge clk); trap_i = 0; lstby_i = 0;
    chk("R6 both masked", stat_o, 8'h00);
    wr(8'hC3, 8'h10);
    @(negedge clk); trap_i = 1; lstby_i = 1;
    @(negedge clk); trap_i = 0; lstby_i = 0;
    chk("R6 trap only", stat_o, 8'h08);
    wr(8'hC3, 8'h08);
    @(negedge clk); lstby_i = 1;
    @(negedge clk); lstby_i = 0;
    chk("R6 local standby", stat_o, 8'h18);
    clr_all();
    wr(8'hC3, 8'h00);
  endtask

  task automatic t_susp();
    wr(8'hC2, 8'h06);
    @(negedge clk); button_n_i = 0; batlow_n_i = 0;
    @(negedge clk);
    chk("R7 suspend master off", stat_o, 8'h00);
    button_n_i = 1; batlow_n_i = 1;
    wr(8'hC3, 8'h02);
    @(negedge clk); button_n_i = 0;
    @(negedge clk);
    chk("R7 button", stat_o, 8'h40);
    batlow_n_i = 0;
    @(negedge clk);
    chk("R7 battery low", stat_o, 8'hC0);
    button_n_i = 1; batlow_n_i = 1;
    clr_all();
    wr(8'hC2, 8'h02);
    @(negedge clk); button_n_i = 0;
    @(negedge clk);
    chk("R7 button own enable off", stat_o, 8'h00);
    button_n_i = 1;
    wr(8'hC2, 8'h00);
    wr(8'hC3, 8'h00);
  endtask

  task automatic t_timer();
    gstby_init_i = 16'd5;
    wr(8'hC3, 8'h04);
    tick_i = 1;
    repeat (4) @(negedge clk);
    tick_i = 0;
    chk("R8 not yet expired", stat_o[5], 1'b0);
    tick_i = 1;
    @(negedge clk); tick_i = 0;
    chk("R8 expiry", stat_o, 8'h20);
    chk("R10 smi on expiry", smi_n_o, 1'b0);
    repeat (3) begin tick_i = 1; @(negedge clk); end
    tick_i = 0;
    clr_all();
    chk("R8 no second expiry", stat_o, 8'h00);
    wr(8'hC3, 8'h00);
  endtask

  task automatic t_timer_act_dis();
    gstby_init_i = 16'd3;
    wr(8'hC3, 8'h04);
    tick_i = 1; repeat (2) @(negedge clk); tick_i = 0;
    activity_i = 1; @(negedge clk); activity_i = 0;
    tick_i = 1; repeat (2) @(negedge clk); tick_i = 0;
    chk("R9 reload delays expiry", stat_o[5], 1'b0);
    tick_i = 1; @(negedge clk); tick_i = 0;
    chk("R9 expiry after reload", stat_o[5], 1'b1);
    clr_all();
    wr(8'hC3, 8'h00);
    gstby_init_i = 16'd2;
    wr(8'hC3, 8'h04);
    tick_i = 1; @(negedge clk); tick_i = 0;
    wr(8'hC3, 8'h00);
    tick_i = 1; repeat (5) @(negedge clk); tick_i = 0;
    chk("R9 disabled no expiry", stat_o, 8'h00);
    gstby_init_i = 16'd0;
    wr(8'hC3, 8'h04);
    tick_i = 1; repeat (5) @(negedge clk); tick_i = 0;
    chk("R8 zero init never expires", stat_o, 8'h00);
    wr(8'hC3, 8'h00);
  endtask

  task automatic t_collide();
    wr(8'hC3, 8'h10);
    @(negedge clk); trap_i = 1;
    @(negedge clk); trap_i = 0;
    chk("R10 trap latched", stat_o, 8'h08);
    trap_i = 1; stat_clr_i = 8'h08;
    @(negedge clk); trap_i = 0; stat_clr_i = 8'h00;
    chk("R10 set wins over clear", stat_o, 8'h08);
    chk("R10 smi held", smi_n_o, 1'b0);
    repeat (2) @(negedge clk);
    chk("R10 sticky", stat_o, 8'h08);
    stat_clr_i = 8'h08;
    @(negedge clk); stat_clr_i = 8'h00;
    chk("R10 clear alone", stat_o, 8'h00);
    chk("R10 smi released", smi_n_o, 1'b1);
    wr(8'hC3, 8'h00);
  endtask

  task automatic t_pirq();
    wr(8'hC2, 8'h08);
    apmc_smi_en_i = 1;
    @(negedge clk); apmc_wr_i = 1;
    @(negedge clk); apmc_wr_i = 0;
    chk("R11 pirq pulse", pirq_o, 1'b1);
    @(negedge clk);
    chk("R11 pirq one cycle", pirq_o, 1'b0);
    apmc_smi_en_i = 0;
    @(negedge clk); apmc_wr_i = 1;
    @(negedge clk); apmc_wr_i = 0;
    chk("R11 control smi disabled", pirq_o, 1'b0);
    wr(8'hC2, 8'h00);
    apmc_smi_en_i = 1;
    @(negedge clk); apmc_wr_i = 1;
    @(negedge clk); apmc_wr_i = 0;
    chk("R11 callback disabled", pirq_o, 1'b0);
    apmc_smi_en_i = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_sw();
    t_sys();
    t_ext();
    t_trap_lstby();
    t_susp();
    t_timer();
    t_timer_act_dis();
    t_collide();
    t_pirq();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule